// File: doc/BRIEF.md
# Remote Frame Auto-Response Matcher

When a CAN controller receives a remote frame, it has to find the transmit message buffer that should answer it. This block does that search. The receiver gives it a one-cycle strobe together with the identifier and the DLC of the remote frame. The block compares the identifier with every message buffer, all in parallel. It accepts only buffers that pass all five eligibility conditions, and only while the controller is in an operating mode that allows remote-frame handling.

If at least one buffer is eligible and matches, the buffer with the lowest index wins. One cycle after the strobe, the block issues write strobes that carry that buffer's index. These strobes tell the buffer storage to replace the stored DLC with the received one and to set the buffer's data-new flag. In the same cycle the block sends an interrupt pulse and sets a sticky status bit, which software clears by writing 1.

Sending the answering data frame and all bit-level protocol work belong to other blocks.

Top module: `remote_frame_matcher`

## Requirements
- R1: Remote frames are evaluated only when `opMode` is 1 (normal), 2 (normal with automatic block send), 3 (receive-only), 4 (single-shot) or 5 (self-test). For codes 0, 6 and 7, nothing is written and no interrupt is raised.
- R2: A buffer whose `bufAssigned` bit is 0 is never selected.
- R3: A buffer is selected only if its 3-bit type field in `bufType` is 3'b000 (transmit buffer).
- R4: A buffer whose `bufReady` bit is 0 is never selected.
- R5: A buffer whose own `bufRtr` bit or `bufTrq` bit is 1 is never selected.
- R6: An eligible buffer is selected only if all `IdW` bits of its identifier equal `rxId`. If no eligible buffer matches, nothing is written and no interrupt is raised.
- R7: If several eligible buffers match, the one with the lowest index is selected.
- R8: The cycle after a strobe that finds a match, `dlcWr` and `dnSet` are both high for exactly one cycle. In that cycle `matchIdx` is the selected buffer and `dlcData` is the received DLC.
- R9: `intPulse` is high in the same cycle as `dlcWr`. `intStatus` becomes 1 in that cycle and stays 1 until `intClrWr` is asserted. A clear and a new match in the same cycle leave the bit set.
- R10: After reset, `dlcWr`, `dnSet`, `intPulse`, `intStatus`, `matchIdx` and `dlcData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxRemoteValid | input | 1 | One-cycle strobe: a remote frame was received |
| rxId | input | IdW | Identifier of the received remote frame |
| rxDlc | input | 4 | DLC of the received remote frame |
| opMode | input | 3 | Current operating mode code |
| bufAssigned | input | NumBuf | Per buffer: assigned to the CAN channel |
| bufType | input | 3*NumBuf | Per buffer: type field, 3 bits each |
| bufReady | input | NumBuf | Per buffer: ready bit |
| bufRtr | input | NumBuf | Per buffer: its own RTR bit |
| bufTrq | input | NumBuf | Per buffer: transmit request bit |
| bufId | input | IdW*NumBuf | Per buffer: identifier, IdW bits each |
| intClrWr | input | 1 | Write 1 to clear the interrupt status bit |
| matchIdx | output | $clog2(NumBuf) | Index of the buffer to update |
| dlcData | output | 4 | New DLC value for the selected buffer |
| dlcWr | output | 1 | Write strobe for the DLC field |
| dnSet | output | 1 | Set strobe for the data-new flag |
| intPulse | output | 1 | One-cycle interrupt pulse |
| intStatus | output | 1 | Sticky interrupt status bit |

## Verification
The checker asserts the following on every cycle:
- the DLC and data-new strobes are always paired;
- no strobe appears without a remote-frame strobe in the cycle before;
- no strobe appears after a strobe received in a disallowed mode;
- the written DLC equals the DLC received in the cycle before;
- the interrupt pulse coincides with the DLC strobe;
- the status bit is sticky until it is cleared.

Only the bench scenarios can show that each eligibility condition blocks selection, that the identifier compare uses every bit, and that the lowest index wins among several matches. Each of these depends on a specific buffer configuration, and that configuration decides the expected index.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  typedef enum logic [2:0] {
    MODE_INIT     = 3'd0,
    MODE_NORMAL   = 3'd1,
    MODE_NORM_ABT = 3'd2,
    MODE_RX_ONLY  = 3'd3,
    MODE_SINGLE   = 3'd4,
    MODE_SELFTEST = 3'd5
  } opMode_e;

  typedef struct packed {
    logic capture;  // latch index and DLC
    logic raise;    // match accepted this cycle
  } rfmStrobes_t;

  localparam logic [2:0] TYPE_TX = 3'b000;
endpackage

// File: rtl/rfm_datapath.sv
module rfm_datapath
  import rfm_pkg::*;
#(
  parameter int NumBuf = 8,
  parameter int IdW    = 29,
  localparam int IdxW  = $clog2(NumBuf)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IdW-1:0]        rxId,
  input  logic [3:0]            rxDlc,
  input  logic [NumBuf-1:0]     bufAssigned,
  input  logic [3*NumBuf-1:0]   bufType,
  input  logic [NumBuf-1:0]     bufReady,
  input  logic [NumBuf-1:0]     bufRtr,
  input  logic [NumBuf-1:0]     bufTrq,
  input  logic [IdW*NumBuf-1:0] bufId,
  input  rfmStrobes_t           strobes,
  output logic                  anyHit,
  output logic [IdxW-1:0]       matchIdx,
  output logic [3:0]            dlcData
);
  logic [NumBuf-1:0] eligible;
  logic [NumBuf-1:0] hitVec;
  logic [IdxW-1:0]   firstIdx;

  for (genvar g = 0; g < NumBuf; g++) begin : gBuf
    assign eligible[g] = bufAssigned[g]
                       & (bufType[3*g +: 3] == TYPE_TX)
                       & bufReady[g]
                       & ~bufRtr[g]
                       & ~bufTrq[g];
    assign hitVec[g]   = eligible[g] & (bufId[IdW*g +: IdW] == rxId);
  end

  assign anyHit = |hitVec;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    firstIdx = '0;
    for (int i = NumBuf - 1; i >= 0; i--) begin
      if (hitVec[i]) firstIdx = IdxW'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchIdx <= '0;
      dlcData  <= '0;
    end else if (strobes.capture) begin
      matchIdx <= firstIdx;
      dlcData  <= rxDlc;
    end
  end
endmodule

// File: rtl/rfm_control.sv
module rfm_control
  import rfm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxRemoteValid,
  input  logic [2:0]  opMode,
  input  logic        anyHit,
  input  logic        intClrWr,
  output rfmStrobes_t strobes,
  output logic        dlcWr,
  output logic        dnSet,
  output logic        intPulse,
  output logic        intStatus
);
  logic modeAllowed;
  logic accept;

  always_comb begin
    unique case (opMode)
      MODE_NORMAL, MODE_NORM_ABT, MODE_RX_ONLY,
      MODE_SINGLE, MODE_SELFTEST: modeAllowed = 1'b1;
      default:                    modeAllowed = 1'b0;
    endcase
  end

  assign accept          = rxRemoteValid & modeAllowed & anyHit;
  assign strobes.capture = accept;
  assign strobes.raise   = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlcWr     <= 1'b0;
      dnSet     <= 1'b0;
      intPulse  <= 1'b0;
      intStatus <= 1'b0;
    end else begin
      dlcWr     <= strobes.capture;
      dnSet     <= strobes.capture;
      intPulse  <= strobes.raise;
      intStatus <= strobes.raise | (intStatus & ~intClrWr);
    end
  end
endmodule

// File: rtl/remote_frame_matcher.sv
module remote_frame_matcher
  import rfm_pkg::*;
#(
  parameter int NumBuf = 8,
  parameter int IdW    = 29,
  localparam int IdxW  = $clog2(NumBuf)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxRemoteValid,
  input  logic [IdW-1:0]        rxId,
  input  logic [3:0]            rxDlc,
  input  logic [2:0]            opMode,
  input  logic [NumBuf-1:0]     bufAssigned,
  input  logic [3*NumBuf-1:0]   bufType,
  input  logic [NumBuf-1:0]     bufReady,
  input  logic [NumBuf-1:0]     bufRtr,
  input  logic [NumBuf-1:0]     bufTrq,
  input  logic [IdW*NumBuf-1:0] bufId,
  input  logic                  intClrWr,
  output logic [IdxW-1:0]       matchIdx,
  output logic [3:0]            dlcData,
  output logic                  dlcWr,
  output logic                  dnSet,
  output logic                  intPulse,
  output logic                  intStatus
);
  rfmStrobes_t strobes;
  logic        anyHit;

  rfm_datapath #(.NumBuf(NumBuf), .IdW(IdW)) u_dp (
    .clk(clk), .rstN(rstN), .rxId(rxId), .rxDlc(rxDlc),
    .bufAssigned(bufAssigned), .bufType(bufType), .bufReady(bufReady),
    .bufRtr(bufRtr), .bufTrq(bufTrq), .bufId(bufId),
    .strobes(strobes), .anyHit(anyHit), .matchIdx(matchIdx), .dlcData(dlcData)
  );

  rfm_control u_ctl (
    .clk(clk), .rstN(rstN), .rxRemoteValid(rxRemoteValid), .opMode(opMode),
    .anyHit(anyHit), .intClrWr(intClrWr), .strobes(strobes),
    .dlcWr(dlcWr), .dnSet(dnSet), .intPulse(intPulse), .intStatus(intStatus)
  );
endmodule

// File: rtl/remote_frame_matcher_chk.sv
module remote_frame_matcher_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxRemoteValid,
  input logic [3:0] rxDlc,
  input logic [2:0] opMode,
  input logic       intClrWr,
  input logic [3:0] dlcData,
  input logic       dlcWr,
  input logic       dnSet,
  input logic       intPulse,
  input logic       intStatus
);
  logic modeOk;
  assign modeOk = (opMode >= 3'd1) && (opMode <= 3'd5);

  assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rxRemoteValid && !modeOk) |=> !dlcWr);

  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxRemoteValid |=> !dlcWr);

  assert_strobes_paired_R8: assert property (@(posedge clk) disable iff (!rstN)
    dlcWr == dnSet);

  assert_dlc_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dlcWr) |-> dlcData == $past(rxDlc));

  assert_pulse_with_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    intPulse == dlcWr);

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus && !intClrWr) |=> intStatus);

  assert_status_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus) |-> intPulse);
endmodule

bind remote_frame_matcher remote_frame_matcher_chk u_chk (
  .clk(clk), .rstN(rstN), .rxRemoteValid(rxRemoteValid), .rxDlc(rxDlc),
  .opMode(opMode), .intClrWr(intClrWr), .dlcData(dlcData), .dlcWr(dlcWr),
  .dnSet(dnSet), .intPulse(intPulse), .intStatus(intStatus)
);

// File: tb/remote_frame_matcher_tb.sv
`timescale 1ns/1ps
module remote_frame_matcher_tb;
  localparam int NumBuf = 8;
  localparam int IdW    = 29;
  localparam int IdxW   = $clog2(NumBuf);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxRemoteValid = 1'b0;
  logic [IdW-1:0] rxId = '0;
  logic [3:0] rxDlc = '0;
  logic [2:0] opMode = 3'd1;
  logic [NumBuf-1:0] bufAssigned = '0, bufReady = '0, bufRtr = '0, bufTrq = '0;
  logic [3*NumBuf-1:0] bufType = '0;
  logic [IdW*NumBuf-1:0] bufId = '0;
  logic intClrWr = 1'b0;
  logic [IdxW-1:0] matchIdx;
  logic [3:0] dlcData;
  logic dlcWr, dnSet, intPulse, intStatus;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  remote_frame_matcher #(.NumBuf(NumBuf), .IdW(IdW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgBuf(input int i, input logic asg, input logic [2:0] typ,
                        input logic rdy, input logic rtr, input logic trq,
                        input logic [IdW-1:0] id);
    bufAssigned[i] = asg;
    bufType[3*i +: 3] = typ;
    bufReady[i] = rdy;
    bufRtr[i] = rtr;
    bufTrq[i] = trq;
    bufId[IdW*i +: IdW] = id;
  endtask

  task automatic clearAll();
    for (int i = 0; i < NumBuf; i++) cfgBuf(i, 1'b0, 3'b111, 1'b0, 1'b0, 1'b0, '0);
  endtask

  // Clears the status bit, then sends one remote frame and checks the response.
  task automatic sendFrame(input string req, input logic [IdW-1:0] id, input logic [3:0] dlc,
                           input logic expHit, input int expIdx);
    @(negedge clk); intClrWr = 1'b1;
    @(negedge clk); intClrWr = 1'b0;
    rxId = id; rxDlc = dlc; rxRemoteValid = 1'b1;
    @(negedge clk); rxRemoteValid = 1'b0;
    chk({req, " dlcWr"}, 32'(dlcWr), 32'(expHit));
    chk({req, " dnSet"}, 32'(dnSet), 32'(expHit));
    chk({req, " intPulse"}, 32'(intPulse), 32'(expHit));
    chk({req, " intStatus"}, 32'(intStatus), 32'(expHit));
    if (expHit) begin
      chk({req, " matchIdx"}, 32'(matchIdx), 32'(expIdx));
      chk({req, " dlcData"}, 32'(dlcData), 32'(dlc));
    end
    @(negedge clk);
    chk({req, " strobe one cycle"}, 32'(dlcWr | dnSet | intPulse), 32'd0);
  endtask

  task automatic testReset();
    chk("R10 dlcWr", 32'(dlcWr), 0);
    chk("R10 dnSet", 32'(dnSet), 0);
    chk("R10 intPulse", 32'(intPulse), 0);
    chk("R10 intStatus", 32'(intStatus), 0);
    chk("R10 matchIdx", 32'(matchIdx), 0);
    chk("R10 dlcData", 32'(dlcData), 0);
  endtask

  task automatic testBasic();
    clearAll();
    cfgBuf(3, 1, 3'b000, 1, 0, 0, 29'h0ABC_1234);
    opMode = 3'd1;
    sendFrame("R8 basic match", 29'h0ABC_1234, 4'd5, 1, 3);
    sendFrame("R6 id mismatch lsb", 29'h0ABC_1235, 4'd5, 0, 0);
    sendFrame("R6 id mismatch msb", 29'h1ABC_1234, 4'd5, 0, 0);
  endtask

  task automatic testEligibility();
    clearAll();
    cfgBuf(2, 0, 3'b000, 1, 0, 0, 29'h55);
    sendFrame("R2 unassigned", 29'h55, 4'd1, 0, 0);
    cfgBuf(2, 1, 3'b001, 1, 0, 0, 29'h55);
    sendFrame("R3 type 001", 29'h55, 4'd1, 0, 0);
    cfgBuf(2, 1, 3'b100, 1, 0, 0, 29'h55);
    sendFrame("R3 type 100", 29'h55, 4'd1, 0, 0);
    cfgBuf(2, 1, 3'b000, 0, 0, 0, 29'h55);
    sendFrame("R4 not ready", 29'h55, 4'd1, 0, 0);
    cfgBuf(2, 1, 3'b000, 1, 1, 0, 29'h55);
    sendFrame("R5 own rtr", 29'h55, 4'd1, 0, 0);
    cfgBuf(2, 1, 3'b000, 1, 0, 1, 29'h55);
    sendFrame("R5 trq set", 29'h55, 4'd1, 0, 0);
    cfgBuf(2, 1, 3'b000, 1, 0, 0, 29'h55);
    sendFrame("R3 eligible again", 29'h55, 4'd9, 1, 2);
  endtask

  task automatic testPriority();
    clearAll();
    cfgBuf(6, 1, 3'b000, 1, 0, 0, 29'h77);
    cfgBuf(4, 1, 3'b000, 1, 0, 0, 29'h77);
    cfgBuf(1, 1, 3'b000, 0, 0, 0, 29'h77);
    sendFrame("R7 lowest eligible", 29'h77, 4'd8, 1, 4);
    cfgBuf(1, 1, 3'b000, 1, 0, 0, 29'h77);
    sendFrame("R7 lower wins", 29'h77, 4'd15, 1, 1);
    cfgBuf(0, 1, 3'b000, 1, 0, 0, 29'h78);
    cfgBuf(7, 1, 3'b000, 1, 0, 0, 29'h78);
    sendFrame("R7 index0", 29'h78, 4'd0, 1, 0);
  endtask

  task automatic testModes();
    clearAll();
    cfgBuf(5, 1, 3'b000, 1, 0, 0, 29'h123);
    for (int m = 0; m < 8; m++) begin
      opMode = 3'(m);
      sendFrame($sformatf("R1 mode %0d", m), 29'h123, 4'd7, (m >= 1 && m <= 5), 5);
    end
    opMode = 3'd1;
  endtask

  task automatic testStatus();
    clearAll();
    cfgBuf(0, 1, 3'b000, 1, 0, 0, 29'h9);
    sendFrame("R9 set", 29'h9, 4'd3, 1, 0);
    repeat (3) @(negedge clk);
    chk("R9 sticky", 32'(intStatus), 1);
    intClrWr = 1'b1;
    @(negedge clk); intClrWr = 1'b0;
    chk("R9 cleared", 32'(intStatus), 0);
    rxId = 29'h9; rxRemoteValid = 1'b1;
    @(negedge clk); rxRemoteValid = 1'b0; intClrWr = 1'b1;
    chk("R9 set again", 32'(intStatus), 1);
    rxRemoteValid = 1'b1;
    @(negedge clk); rxRemoteValid = 1'b0; intClrWr = 1'b0;
    chk("R9 set beats clear", 32'(intStatus), 1);
    @(negedge clk);
    chk("R9 after collision", 32'(intStatus), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBasic();
    testEligibility();
    testPriority();
    testModes();
    testStatus();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule